// File: doc/BRIEF.md
# Debug Pin Source Crossbar

This block sits between a chip's internal debug sources and a handful of shared debug pins. Each pin owns one 32-bit control word on a small memory-mapped register bus. An 8-bit selector in that word picks what drives the pin. The choices are tri-state, a trigger line, one of the system-trace data bits, the system-trace clock, the lines of two other trace sources, or a high-speed real-time data channel. Any source may be placed on any pin, so software decides, for example, which pin carries the trace clock.

Software can also take a pin over directly in a bit-bang mode. In that mode it writes the pin's output level and output-enable, and it can read back the pin's live input level through a two-flop synchronizer. A write-once lock bit per pin keeps that pin on debug functions only until the next reset. The register bus has plain write and read strobes. Reads return their data in the same cycle as the strobe. The design has no streaming interface, so no valid/ready handshake applies.

Top module: `dbg_pin_xbar`

## Requirements
- R1: After reset, every pin has pin_oe low and pin_out low. With the pin input low, every control word reads 0x1600_0000: selector 0, lock 0, drive value 1, drive enable 1, bit 28 reading 1.
- R2: Control word i sits at byte address 0x80 + 4*i, for i from 0 to 4. Its selector field is bits 7:0, can be written and read back, and changes only when that word is written.
- R3: Outside bit-bang mode, a selector value k from 1 to 14 puts dbg_src[k] on pin_out with pin_oe high, on any pin. The codes are: 1 trigger; 2 to 5 system-trace data bits 0 to 3; 6 system-trace clock; 7, 8, 9 and 10 the second trace source's data A, data B, control and clock; 11, 12 and 13 the third trace source's data A, data B and clock; 14 the real-time data channel.
- R4: Outside bit-bang mode, selector 0 and any selector from 15 to 255 give pin_oe low and pin_out low. pin_out is never high while pin_oe is low.
- R5: A write with bit 28 set to an unlocked word enters bit-bang mode and stores bit 26 (drive value) and bit 25 (drive enable). While the mode is on, pin_oe equals the stored enable and pin_out equals the stored value ANDed with it, whatever the selector says.
- R6: A write with bit 28 clear leaves bit-bang mode and ignores bits 26 and 25. They read back unchanged, and the pin follows its selector again.
- R7: Bit 31 is the lock. Writing a 1 sets it, and it stays set until reset. A locked pin never enters bit-bang mode, and its stored bits 26 and 25 do not change. Its selector stays writable.
- R8: Bit 27 reads the pin input after a two-flop synchronizer. A change made just after a clock edge is not visible after one further edge and is visible after two.
- R9: Reads of a control word return bits 30, 29 and 24:8 as 0 and bit 28 as 1.
- R10: Reads of any address that is not a word-aligned control word return 0. Writes to such addresses change no pin.
- R11: bus_rdata is valid in the same cycle as bus_rd_en and is 0 whenever bus_rd_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_en | input | 1 | Write strobe, one cycle per write |
| bus_rd_en | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational with bus_rd_en |
| dbg_src | input | 15 | Debug sources; bit k is the source for selector k (bit 0 unused) |
| pin_in | input | 5 | Pin input levels from the pads |
| pin_out | output | 5 | Pin output levels to the pads |
| pin_oe | output | 5 | Active-high pad output-enables |

## Verification
The assertions assume the bus is used one strobe at a time and that rst_n is held low from time zero until the first clock edges have passed. The lock and selector properties depend on that reset. The stimulus drives each strobe for exactly one cycle and never raises write and read together. It changes bus and pad inputs only at falling edges, so the synchronizer latency is measured from a known edge. The dbg_src patterns set the selected bit opposite to its neighbours, so a wrong mux index shows up as a wrong pin level.

// File: rtl/dpx_pkg.sv
package dpx_pkg;
  localparam int SEL_W    = 8;
  localparam int NUM_SRC  = 15;   // selector codes 0..14, code 0 has no source
  localparam int LOCK_B   = 31;
  localparam int BIO_EN_B = 28;
  localparam int PIN_IN_B = 27;
  localparam int BIO_OUT_B = 26;
  localparam int BIO_OE_B = 25;

  typedef struct packed {
    logic             lock;
    logic             bio_en;
    logic             bio_out;
    logic             bio_oe;
    logic [SEL_W-1:0] sel;
  } pin_cfg_t;
endpackage

// File: rtl/dpx_sync.sv
module dpx_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/dpx_pin_reg.sv
module dpx_pin_reg
  import dpx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic [31:0] wdata,
  output pin_cfg_t    cfg
);
  logic lock_nx;
  logic bio_nx;
  logic unused_wbits;

  assign lock_nx      = cfg.lock | wdata[LOCK_B];
  assign bio_nx       = wdata[BIO_EN_B] & ~lock_nx;
  assign unused_wbits = ^{wdata[30:27], wdata[24:SEL_W]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg.lock    <= 1'b0;
      cfg.bio_en  <= 1'b0;
      cfg.bio_out <= 1'b1;
      cfg.bio_oe  <= 1'b1;
      cfg.sel     <= '0;
    end else if (wr) begin
      cfg.lock   <= lock_nx;
      cfg.bio_en <= bio_nx;
      cfg.sel    <= wdata[SEL_W-1:0];
      if (bio_nx) begin
        cfg.bio_out <= wdata[BIO_OUT_B];
        cfg.bio_oe  <= wdata[BIO_OE_B];
      end
    end
  end
endmodule

// File: rtl/dpx_pin_mux.sv
module dpx_pin_mux
  import dpx_pkg::*;
(
  input  pin_cfg_t             cfg,
  input  logic [NUM_SRC-1:0]   src,
  output logic                 out,
  output logic                 oe
);
  always_comb begin
    out = 1'b0;
    oe  = 1'b0;
    if (cfg.bio_en) begin
      oe  = cfg.bio_oe;
      out = cfg.bio_out & cfg.bio_oe;
    end else if (cfg.sel != '0 && cfg.sel < SEL_W'(NUM_SRC)) begin
      oe  = 1'b1;
      out = src[cfg.sel[3:0]];
    end
  end
endmodule

// File: rtl/dbg_pin_xbar.sv
module dbg_pin_xbar
  import dpx_pkg::*;
#(
  parameter int NUM_PINS  = 5,
  parameter int ADDR_W    = 8,
  parameter int BASE_ADDR = 'h80
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr_en,
  input  logic                bus_rd_en,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [NUM_SRC-1:0]  dbg_src,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe
);
  localparam int SPAN  = NUM_PINS * 4;
  localparam int IDX_W = ADDR_W - 2;

  logic [ADDR_W-1:0]         offs;
  logic                      hit;
  logic [IDX_W-1:0]          idx;
  logic [NUM_PINS-1:0]       pin_sync;
  logic [NUM_PINS-1:0]       pin_lock;
  logic [NUM_PINS-1:0]       pin_bitio;
  logic [NUM_PINS*SEL_W-1:0] sel_flat;
  logic [31:0]               word [NUM_PINS];
  pin_cfg_t                  cfg  [NUM_PINS];
  logic                      unused_src0;

  assign unused_src0 = dbg_src[0];
  assign offs = bus_addr - ADDR_W'(BASE_ADDR);
  assign hit  = (bus_addr >= ADDR_W'(BASE_ADDR)) && (offs < ADDR_W'(SPAN))
                && (offs[1:0] == 2'b00);
  assign idx  = offs[ADDR_W-1:2];

  dpx_sync #(.W(NUM_PINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_sync)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic wr_i;
    assign wr_i = bus_wr_en & hit & (idx == IDX_W'(i));

    dpx_pin_reg u_reg (
      .clk(clk), .rst_n(rst_n), .wr(wr_i), .wdata(bus_wdata), .cfg(cfg[i])
    );

    dpx_pin_mux u_mux (
      .cfg(cfg[i]), .src(dbg_src), .out(pin_out[i]), .oe(pin_oe[i])
    );

    assign pin_lock[i]  = cfg[i].lock;
    assign pin_bitio[i] = cfg[i].bio_en;
    assign sel_flat[i*SEL_W +: SEL_W] = cfg[i].sel;

    always_comb begin
      word[i]            = '0;
      word[i][LOCK_B]    = cfg[i].lock;
      word[i][BIO_EN_B]  = 1'b1;
      word[i][PIN_IN_B]  = pin_sync[i];
      word[i][BIO_OUT_B] = cfg[i].bio_out;
      word[i][BIO_OE_B]  = cfg[i].bio_oe;
      word[i][SEL_W-1:0] = cfg[i].sel;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd_en && hit) begin
      for (int i = 0; i < NUM_PINS; i++) begin
        if (idx == IDX_W'(i)) bus_rdata = word[i];
      end
    end
  end
endmodule

// File: rtl/dpx_checker.sv
module dpx_checker #(
  parameter int NUM_PINS = 5,
  parameter int SEL_W    = 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      bus_wr_en,
  input logic                      bus_rd_en,
  input logic [31:0]               bus_rdata,
  input logic [NUM_PINS-1:0]       pin_out,
  input logic [NUM_PINS-1:0]       pin_oe,
  input logic [NUM_PINS-1:0]       pin_lock,
  input logic [NUM_PINS-1:0]       pin_bitio,
  input logic [NUM_PINS*SEL_W-1:0] sel_flat
);
  AST_NO_DRIVE_WITHOUT_OE: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out & ~pin_oe) == '0); // R4

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (~pin_lock & $past(pin_lock)) == '0); // R7

  AST_LOCK_BLOCKS_BITIO: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_lock & pin_bitio) == '0); // R7

  AST_SEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_wr_en) |-> $stable(sel_flat)); // R2

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd_en |-> (bus_rdata[30:29] == 2'b00 && bus_rdata[24:8] == '0)); // R9

  AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_en |-> bus_rdata == '0); // R11
endmodule

bind dbg_pin_xbar dpx_checker #(.NUM_PINS(NUM_PINS), .SEL_W(dpx_pkg::SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
  .bus_rdata(bus_rdata), .pin_out(pin_out), .pin_oe(pin_oe),
  .pin_lock(pin_lock), .pin_bitio(pin_bitio), .sel_flat(sel_flat)
);

// File: tb/dbg_pin_xbar_test.sv
module dbg_pin_xbar_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr_en = 1'b0;
  logic        bus_rd_en = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [14:0] dbg_src = '0;
  logic [4:0]  pin_in = '0;
  logic [4:0]  pin_out;
  logic [4:0]  pin_oe;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_pin_xbar uut (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dbg_src(dbg_src), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  typedef struct packed {
    logic [2:0]  pin;
    logic [7:0]  sel;
    logic [14:0] src;
    logic        e_out;
    logic        e_oe;
  } vec_t;

  localparam vec_t VECS [14] = '{
    '{3'd0, 8'd1,   15'h0002, 1'b1, 1'b1},
    '{3'd1, 8'd2,   15'h0004, 1'b1, 1'b1},
    '{3'd2, 8'd6,   15'h7FBF, 1'b0, 1'b1},
    '{3'd4, 8'd6,   15'h0040, 1'b1, 1'b1},
    '{3'd3, 8'd5,   15'h0020, 1'b1, 1'b1},
    '{3'd0, 8'd10,  15'h0400, 1'b1, 1'b1},
    '{3'd1, 8'd13,  15'h2000, 1'b1, 1'b1},
    '{3'd2, 8'd14,  15'h4000, 1'b1, 1'b1},
    '{3'd3, 8'd14,  15'h3FFF, 1'b0, 1'b1},
    '{3'd2, 8'd7,   15'h0080, 1'b1, 1'b1},
    '{3'd3, 8'd9,   15'h0200, 1'b1, 1'b1},
    '{3'd4, 8'd0,   15'h7FFF, 1'b0, 1'b0},
    '{3'd0, 8'd15,  15'h7FFF, 1'b0, 1'b0},
    '{3'd1, 8'd255, 15'h7FFF, 1'b0, 1'b0}
  };

  function automatic logic [7:0] pa(input int p);
    return 8'h80 + 8'(p * 4);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  // called at a falling edge; samples combinational read data mid-phase
  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd_en = 1'b1;
    #1 d = bus_rdata;
    bus_rd_en = 1'b0;
    #1;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 oe", {27'd0, pin_oe}, 32'd0);
    check("R1 out", {27'd0, pin_out}, 32'd0);
    for (int p = 0; p < 5; p++) begin
      bus_read(pa(p), rd);
      check("R1 word", rd, 32'h1600_0000);
    end
    // R11 idle read data
    bus_addr = 8'h80; #1;
    check("R11 idle", bus_rdata, 32'd0);
    @(negedge clk);

    // R2/R3/R4 table walk
    foreach (VECS[k]) begin
      dbg_src = VECS[k].src;
      bus_write(pa(int'(VECS[k].pin)), {24'd0, VECS[k].sel});
      check("R3/R4 out", {31'd0, pin_out[VECS[k].pin]}, {31'd0, VECS[k].e_out});
      check("R3/R4 oe",  {31'd0, pin_oe[VECS[k].pin]},  {31'd0, VECS[k].e_oe});
      bus_read(pa(int'(VECS[k].pin)), rd);
      check("R2 sel", {24'd0, rd[7:0]}, {24'd0, VECS[k].sel});
    end

    // R5 bit-bang takes priority over selector 3
    dbg_src = 15'h0000;
    bus_write(pa(2), 32'h1600_0003);
    check("R5 out hi", {30'd0, pin_out[2], pin_oe[2]}, 32'd3);
    dbg_src = 15'h0008;
    bus_write(pa(2), 32'h1200_0003);
    check("R5 out lo", {30'd0, pin_out[2], pin_oe[2]}, 32'd1);
    bus_read(pa(2), rd);
    check("R5 readback", rd, 32'h1200_0003);

    // R6 leaving bit-bang, bits 26/25 ignored
    bus_write(pa(2), 32'h0600_0003);
    check("R6 follows sel", {30'd0, pin_out[2], pin_oe[2]}, 32'd3);
    bus_read(pa(2), rd);
    check("R6 readback", rd, 32'h1200_0003);

    // R7 lock is write-once and blocks bit-bang
    dbg_src = 15'h0006;
    bus_write(pa(0), 32'h8000_0002);
    bus_read(pa(0), rd);
    check("R7 locked", rd, 32'h9600_0002);
    bus_write(pa(0), 32'h1000_0001);
    bus_read(pa(0), rd);
    check("R7 sticky", rd, 32'h9600_0001);
    check("R7 sel live", {30'd0, pin_out[0], pin_oe[0]}, 32'd3);
    bus_write(pa(0), 32'h1600_0000);
    check("R7 no bitio", {30'd0, pin_out[0], pin_oe[0]}, 32'd0);

    // R9 reserved and fixed bits, with all-ones write (also locks pin 3)
    bus_write(pa(3), 32'hFFFF_FFFF);
    bus_read(pa(3), rd);
    check("R9 mask", rd, 32'h9600_00FF);
    check("R7 lock blocks oe", {31'd0, pin_oe[3]}, 32'd0);

    // R8 two-flop synchronizer on pin input
    pin_in = 5'b10000;
    @(negedge clk);
    bus_read(pa(4), rd);
    check("R8 one edge", {31'd0, rd[27]}, 32'd0);
    @(negedge clk);
    bus_read(pa(4), rd);
    check("R8 two edges", {31'd0, rd[27]}, 32'd1);

    // R10 unmapped addresses
    bus_read(8'h7C, rd);
    check("R10 below", rd, 32'd0);
    bus_read(8'h94, rd);
    check("R10 above", rd, 32'd0);
    bus_read(8'h81, rd);
    check("R10 misaligned", rd, 32'd0);
    @(negedge clk);
    dbg_src = 15'h7FFF;
    bus_write(8'h94, 32'h0000_0001);
    bus_write(8'h7C, 32'h0000_0001);
    bus_write(8'h85, 32'h0000_0001);
    check("R10 pins unchanged", {27'd0, pin_oe}, 32'h0000_0004);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule